// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block divides integers one quotient bit per clock, using a restoring shift-and-subtract loop. It serves three operand forms. The word form divides a 32-bit dividend by a 16-bit divisor and returns one packed 32-bit result. The long form divides a 32-bit dividend by a 32-bit divisor. The wide form divides a 64-bit dividend, built from a high and a low source register, by a 32-bit divisor. Each form runs either signed or unsigned. Signed operands are reduced to magnitudes before the loop, and the signs are applied after it. The quotient truncates toward zero, and the remainder takes the sign of the dividend.

A caller pulses `start` with the operands and the two destination indices. It then waits for `done`. The block holds the N, Z and V condition flags in its own state and updates them at the end of every operation. It reports the carry flag as always clear. A zero divisor finishes at once with a trap pulse and writes nothing. On overflow the block sets V, clears Z, keeps N and writes nothing.

Top module: `seq_divider`

## Requirements
- R1: Word form, unsigned: the written value holds the 16-bit remainder in bits 31:16 and the 16-bit quotient in bits 15:0. The operands are dividend = `dvd_lo` and divisor = `dvs[15:0]`. Only `quo_wen` is raised; `rem_wen` stays low.
- R2: When the effective divisor is zero, `done` and `dz_trap` rise for one cycle right after the start edge. Neither write enable rises, and N, Z and V keep their values.
- R3: `flag_c` reads 0 after every operation, including divide-by-zero and overflow.
- R4: Unsigned overflow occurs when the quotient exceeds the result width: 16 bits in the word form, 32 bits in the long and wide forms.
- R5: On overflow, `flag_v` becomes 1 and `flag_z` becomes 0. `flag_n` keeps its previous value, and neither write enable rises.
- R6: Without overflow or trap, N is the top bit of the quotient at the result width, Z is 1 exactly when that quotient is zero, and V is 0.
- R7: Signed operation is selected by `op_signed`=1. The quotient truncates toward zero and the remainder takes the dividend's sign. Overflow occurs when the quotient does not fit the signed result width, which includes the most negative dividend divided by -1.
- R8: Long form (`op_form`=1): the 32-bit dividend is `dvd_lo`. `quo_data` receives the 32-bit quotient and `rem_data` the 32-bit remainder, and both are written.
- R9: Wide form (`op_form`=2 or 3): `dvd_hi` supplies dividend bits 63:32 and `dvd_lo` bits 31:0. When `quo_dst` equals `rem_dst`, only the quotient is written.
- R10: For a nonzero divisor, `done` rises 33 clock edges after the start edge in the word and long forms and 65 edges after it in the wide form. It lasts one cycle.
- R11: After reset, `done`, `dz_trap`, both write enables and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_signed | input | 1 | 1 = signed division |
| op_form | input | 2 | 0 word, 1 long, 2/3 wide |
| dvd_hi | input | 32 | Dividend bits 63:32 (wide form) |
| dvd_lo | input | 32 | Dividend low word |
| dvs | input | 32 | Divisor (bits 15:0 in word form) |
| quo_dst | input | 3 | Quotient destination index |
| rem_dst | input | 3 | Remainder destination index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | One-cycle divide-by-zero trap |
| quo_wen | output | 1 | Write quotient (or packed word result) |
| rem_wen | output | 1 | Write remainder |
| quo_idx | output | 3 | Quotient destination index for the write |
| rem_idx | output | 3 | Remainder destination index for the write |
| quo_data | output | 32 | Quotient or packed word result |
| rem_data | output | 32 | Remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Directed operands cover each form in both signednesses:
- A plain unsigned quotient confirms the word packing and the long-form register pairing.
- A negative dividend over a positive divisor separates truncation toward zero from floor division, and it shows the remainder's sign.
- Quotients just past the unsigned and signed limits, including the most negative dividend over -1, separate correct overflow detection from wrap-around.
- A zero divisor separates the trap path from the arithmetic path.
- A zero quotient and an exactly representable most-negative quotient exercise Z and N at the boundary.

Random operands, with divisors drawn often from zero, one, all-ones and the most negative value, then mix these regimes. Each one runs against a model based on the division operator, with N, Z and V carried from operation to operation.

// File: rtl/div_pkg.sv
// Package: shared operand-form encoding for the sequential divider.
// Assumes: callers encode op_form as below; value 3 behaves as the wide form.
package div_pkg;
    typedef enum logic [1:0] {
        FORM_WORD = 2'd0,
        FORM_LONG = 2'd1,
        FORM_WIDE = 2'd2,
        FORM_WIDX = 2'd3
    } div_form_e;
endpackage

// File: rtl/div_prep.sv
// Module: div_prep - turns raw operands into unsigned magnitudes, sign flags,
// a left-aligned dividend for the iteration core and the number of steps.
// Assumes: purely combinational; the caller samples the outputs on start.
module div_prep
    import div_pkg::*;
#(
    parameter  int XW = 32,
    localparam int DW = 2 * XW,
    localparam int HW = XW / 2,
    localparam int SW = $clog2(DW) + 1
) (
    input  logic          is_signed,
    input  div_form_e     form,
    input  logic [XW-1:0] dvd_hi,
    input  logic [XW-1:0] dvd_lo,
    input  logic [XW-1:0] dvs,
    output logic [DW-1:0] dvd_aligned,
    output logic [XW-1:0] dvs_mag,
    output logic          quo_neg,
    output logic          rem_neg,
    output logic          dvs_zero,
    output logic [SW-1:0] steps
);
    logic          wide;
    logic [DW-1:0] dvd_full, dvd_mag;
    logic [XW-1:0] dvs_full;
    logic          dvd_neg, dvs_neg;

    // Widen the operands according to form and signedness.
    always_comb begin
        wide = form[1];
        if (wide)
            dvd_full = {dvd_hi, dvd_lo};
        else
            dvd_full = {{XW{is_signed & dvd_lo[XW-1]}}, dvd_lo};
        if (form == FORM_WORD)
            dvs_full = {{HW{is_signed & dvs[HW-1]}}, dvs[HW-1:0]};
        else
            dvs_full = dvs;
    end

    // Take magnitudes and record the signs the result fix-up will need.
    always_comb begin
        dvd_neg  = is_signed & dvd_full[DW-1];
        dvs_neg  = is_signed & dvs_full[XW-1];
        dvd_mag  = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
        dvs_mag  = dvs_neg ? (~dvs_full + 1'b1) : dvs_full;
        quo_neg  = dvd_neg ^ dvs_neg;
        rem_neg  = dvd_neg;
        dvs_zero = (dvs_full == '0);
    end

    // Left-align short dividends so the quotient always lands in the low bits.
    always_comb begin
        if (wide) begin
            dvd_aligned = dvd_mag;
            steps       = SW'(DW);
        end else begin
            dvd_aligned = {dvd_mag[XW-1:0], {XW{1'b0}}};
            steps       = SW'(XW);
        end
    end
endmodule

// File: rtl/div_core.sv
// Module: div_core - radix-2 restoring divider, one quotient bit per cycle.
// Assumes: go is only raised while idle and with a nonzero divisor; the
// dividend is left-aligned so that after 'steps' shifts quo holds the quotient.
module div_core #(
    parameter  int XW = 32,
    localparam int DW = 2 * XW,
    localparam int SW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dvd,
    input  logic [XW-1:0] dvs,
    input  logic [SW-1:0] steps,
    output logic          busy,
    output logic          fin,
    output logic [DW-1:0] quo,
    output logic [XW-1:0] rem
);
    logic [XW-1:0] rem_q, dvs_q;
    logic [DW-1:0] quo_q;
    logic [SW-1:0] cnt_q;
    logic          busy_q, fin_q;
    logic [XW:0]   shifted;
    logic [XW+1:0] trial;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, quo_q[DW-1]};
        trial   = {1'b0, shifted} - {2'b00, dvs_q};
    end

    // Load on go, then shift/subtract once per cycle until the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dvs_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= dvd;
                dvs_q  <= dvs;
                cnt_q  <= steps;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= trial[XW+1] ? shifted[XW-1:0] : trial[XW-1:0];
                quo_q <= {quo_q[DW-2:0], ~trial[XW+1]};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == SW'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < dvs_q)); // R1
endmodule

// File: rtl/div_fix.sv
// Module: div_fix - applies signs to the magnitudes, detects overflow at the
// result width, packs the word form and derives N/Z and the remainder write.
// Assumes: purely combinational; inputs are stable while fin is high.
module div_fix
    import div_pkg::*;
#(
    parameter  int XW = 32,
    localparam int DW = 2 * XW,
    localparam int HW = XW / 2
) (
    input  logic          is_signed,
    input  div_form_e     form,
    input  logic          quo_neg,
    input  logic          rem_neg,
    input  logic          dst_same,
    input  logic [DW-1:0] quo_mag,
    input  logic [XW-1:0] rem_mag,
    output logic          ovf,
    output logic [XW-1:0] quo_word,
    output logic [XW-1:0] rem_word,
    output logic          nf,
    output logic          zf,
    output logic          rem_wr
);
    logic          word;
    logic [DW-1:0] quo_s, ulim, slim;
    logic [XW-1:0] rem_s;

    // Signed results and the width-dependent overflow limits.
    always_comb begin
        word  = (form == FORM_WORD);
        quo_s = quo_neg ? (~quo_mag + 1'b1) : quo_mag;
        rem_s = rem_neg ? (~rem_mag + 1'b1) : rem_mag;
        ulim  = word ? (DW'(1) << HW) : (DW'(1) << XW);
        slim  = ulim >> 1;
        if (is_signed)
            ovf = quo_neg ? (quo_mag > slim) : (quo_mag >= slim);
        else
            ovf = (quo_mag >= ulim);
    end

    // Pack the destination values and the quotient flags at result width.
    always_comb begin
        if (word) begin
            quo_word = {rem_s[HW-1:0], quo_s[HW-1:0]};
            nf       = quo_s[HW-1];
            zf       = (quo_s[HW-1:0] == '0);
        end else begin
            quo_word = quo_s[XW-1:0];
            nf       = quo_s[XW-1];
            zf       = (quo_s[XW-1:0] == '0);
        end
        rem_word = rem_s;
        rem_wr   = !word && !dst_same;
    end
endmodule

// File: rtl/seq_divider.sv
// Module: seq_divider - top of the sequential divider: accepts an operation,
// traps zero divisors, runs the core and updates flags and write enables.
// Assumes: start is honoured only while idle; flags live here and persist.
module seq_divider
    import div_pkg::*;
#(
    parameter  int XW = 32,
    parameter  int RW = 3,
    localparam int DW = 2 * XW,
    localparam int SW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_signed,
    input  logic [1:0]    op_form,
    input  logic [XW-1:0] dvd_hi,
    input  logic [XW-1:0] dvd_lo,
    input  logic [XW-1:0] dvs,
    input  logic [RW-1:0] quo_dst,
    input  logic [RW-1:0] rem_dst,
    output logic          busy,
    output logic          done,
    output logic          dz_trap,
    output logic          quo_wen,
    output logic          rem_wen,
    output logic [RW-1:0] quo_idx,
    output logic [RW-1:0] rem_idx,
    output logic [XW-1:0] quo_data,
    output logic [XW-1:0] rem_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    div_form_e     form_in, form_q;
    logic          signed_q, qneg_q, rneg_q, busy_q;
    logic [DW-1:0] dvd_al, core_quo;
    logic [XW-1:0] dvs_mag, core_rem, quo_word, rem_word;
    logic [SW-1:0] steps;
    logic          p_qneg, p_rneg, p_zero, core_go, core_busy, core_fin;
    logic          ovf, nf, zf, rem_wr;

    assign form_in = div_form_e'(op_form);
    assign core_go = start && !busy_q && !p_zero;

    div_prep #(.XW(XW)) u_prep (
        .is_signed(op_signed), .form(form_in), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
        .dvs(dvs), .dvd_aligned(dvd_al), .dvs_mag(dvs_mag), .quo_neg(p_qneg),
        .rem_neg(p_rneg), .dvs_zero(p_zero), .steps(steps)
    );

    div_core #(.XW(XW)) u_core (
        .clk(clk), .rst_n(rst_n), .go(core_go), .dvd(dvd_al), .dvs(dvs_mag),
        .steps(steps), .busy(core_busy), .fin(core_fin), .quo(core_quo), .rem(core_rem)
    );

    div_fix #(.XW(XW)) u_fix (
        .is_signed(signed_q), .form(form_q), .quo_neg(qneg_q), .rem_neg(rneg_q),
        .dst_same(quo_idx == rem_idx), .quo_mag(core_quo), .rem_mag(core_rem),
        .ovf(ovf), .quo_word(quo_word), .rem_word(rem_word), .nf(nf), .zf(zf),
        .rem_wr(rem_wr)
    );

    // Accept operations, trap zero divisors and retire core results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            signed_q <= 1'b0;
            form_q   <= FORM_WORD;
            qneg_q   <= 1'b0;
            rneg_q   <= 1'b0;
            quo_idx  <= '0;
            rem_idx  <= '0;
            done     <= 1'b0;
            dz_trap  <= 1'b0;
            quo_wen  <= 1'b0;
            rem_wen  <= 1'b0;
            quo_data <= '0;
            rem_data <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_v   <= 1'b0;
        end else begin
            done    <= 1'b0;
            dz_trap <= 1'b0;
            quo_wen <= 1'b0;
            rem_wen <= 1'b0;
            if (start && !busy_q) begin
                signed_q <= op_signed;
                form_q   <= form_in;
                qneg_q   <= p_qneg;
                rneg_q   <= p_rneg;
                quo_idx  <= quo_dst;
                rem_idx  <= rem_dst;
                if (p_zero) begin
                    done    <= 1'b1;
                    dz_trap <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end
            if (core_fin) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
                if (ovf) begin
                    flag_v <= 1'b1;
                    flag_z <= 1'b0;
                end else begin
                    flag_n   <= nf;
                    flag_z   <= zf;
                    flag_v   <= 1'b0;
                    quo_wen  <= 1'b1;
                    rem_wen  <= rem_wr;
                    quo_data <= quo_word;
                    rem_data <= rem_word;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign flag_c = 1'b0;

    AST_BUSY_MATCHES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> busy_q); // R10
    AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap |-> (!quo_wen && !rem_wen)); // R2
    AST_DZ_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap |-> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v))); // R2
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (!quo_wen && !rem_wen)); // R5
    AST_OVF_N_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz_trap && flag_v) |-> ($stable(flag_n) && !flag_z)); // R5
    AST_REM_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        rem_wen |-> (rem_idx != quo_idx)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_signed = 1'b0;
    logic [1:0]    op_form = 2'd0;
    logic [XW-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic [2:0]    quo_dst = 3'd0, rem_dst = 3'd1;
    logic          busy, done, dz_trap, quo_wen, rem_wen;
    logic [2:0]    quo_idx, rem_idx;
    logic [XW-1:0] quo_data, rem_data;
    logic          flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int failures = 0;
    logic exp_n = 1'b0, exp_z = 1'b0, exp_v = 1'b0;

    seq_divider u_seq_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
        .op_form(op_form), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .quo_dst(quo_dst), .rem_dst(rem_dst), .busy(busy), .done(done),
        .dz_trap(dz_trap), .quo_wen(quo_wen), .rem_wen(rem_wen),
        .quo_idx(quo_idx), .rem_idx(rem_idx), .quo_data(quo_data),
        .rem_data(rem_data), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Reference results from the division operator on magnitudes.
    task automatic model(input bit sg, input logic [1:0] form, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] dv,
                         output bit dz, output bit ovf, output logic [31:0] qo,
                         output logic [31:0] ro, output bit nf, output bit zf);
        logic [63:0] a, b, am, bm, mq, mr, qs, rs;
        bit an, bn, qn, word;
        int w;
        word = (form == 2'd0);
        if (form[1]) a = {hi, lo};
        else a = sg ? {{32{lo[31]}}, lo} : {32'd0, lo};
        if (word) b = sg ? {{48{dv[15]}}, dv[15:0]} : {48'd0, dv[15:0]};
        else b = sg ? {{32{dv[31]}}, dv} : {32'd0, dv};
        an = sg && a[63];
        bn = sg && b[63];
        am = an ? -a : a;
        bm = bn ? -b : b;
        dz = (bm == 64'd0);
        mq = dz ? 64'd0 : am / bm;
        mr = dz ? 64'd0 : am % bm;
        qn = an ^ bn;
        w = word ? 16 : 32;
        if (sg) ovf = qn ? (mq > (64'd1 << (w - 1))) : (mq >= (64'd1 << (w - 1)));
        else ovf = (mq >= (64'd1 << w));
        qs = qn ? -mq : mq;
        rs = an ? -mr : mr;
        qo = word ? {rs[15:0], qs[15:0]} : qs[31:0];
        ro = rs[31:0];
        nf = qs[w-1];
        zf = word ? (qs[15:0] == 16'd0) : (qs[31:0] == 32'd0);
    endtask

    task automatic run_op(input bit sg, input logic [1:0] form, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] dv,
                          input logic [2:0] qd, input logic [2:0] rd);
        bit dz, ovf, nf, zf, rwe;
        logic [31:0] qo, ro;
        int lat, exp_lat;
        model(sg, form, hi, lo, dv, dz, ovf, qo, ro, nf, zf);
        rwe = (form != 2'd0) && (qd != rd);
        exp_lat = dz ? 0 : (form[1] ? 65 : 33);
        @(negedge clk);
        op_signed = sg; op_form = form; dvd_hi = hi; dvd_lo = lo; dvs = dv;
        quo_dst = qd; rem_dst = rd; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R10 latency", 64'(lat), 64'(exp_lat));
        chk(dz_trap == dz, "R2 trap", 64'(dz_trap), 64'(dz));
        chk(flag_c == 1'b0, "R3 carry", 64'(flag_c), 64'd0);
        if (!dz) begin
            if (ovf) begin
                exp_v = 1'b1; exp_z = 1'b0;
            end else begin
                exp_n = nf; exp_z = zf; exp_v = 1'b0;
            end
        end
        chk(flag_v == exp_v, ovf ? "R4/R7 overflow V" : "R6 V", 64'(flag_v), 64'(exp_v));
        chk(flag_z == exp_z, ovf ? "R5 Z" : "R6 Z", 64'(flag_z), 64'(exp_z));
        chk(flag_n == exp_n, ovf ? "R5 N held" : "R6 N", 64'(flag_n), 64'(exp_n));
        chk(quo_wen == (!dz && !ovf), "R5 quotient write", 64'(quo_wen), 64'(!dz && !ovf));
        chk(rem_wen == (!dz && !ovf && rwe), "R9 remainder write", 64'(rem_wen),
            64'(!dz && !ovf && rwe));
        if (!dz && !ovf) begin
            chk(quo_data == qo, form == 2'd0 ? "R1 packed result" : "R8 quotient",
                64'(quo_data), 64'(qo));
            if (rwe) chk(rem_data == ro, "R7 remainder", 64'(rem_data), 64'(ro));
        end
    endtask

    function automatic logic [31:0] pick(input int sel);
        case (sel)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h0000_8000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(!done && !dz_trap && !quo_wen && !rem_wen, "R11 reset outputs",
            64'({done, dz_trap, quo_wen, rem_wen}), 64'd0);
        chk(!flag_n && !flag_z && !flag_v && !flag_c, "R11 reset flags",
            64'({flag_n, flag_z, flag_v, flag_c}), 64'd0);
        // R1 unsigned word
        run_op(1'b0, 2'd0, 32'd0, 32'd100000, 32'd7, 3'd2, 3'd3);
        // R6 zero quotient
        run_op(1'b0, 2'd0, 32'd0, 32'd3, 32'd5, 3'd2, 3'd3);
        // R4 word overflow
        run_op(1'b0, 2'd0, 32'd0, 32'h0001_0000, 32'd1, 3'd2, 3'd3);
        // R2 zero divisor (upper divisor bits ignored in word form)
        run_op(1'b0, 2'd0, 32'd0, 32'd55, 32'hABCD_0000, 3'd2, 3'd3);
        // R7 signed word truncation and remainder sign
        run_op(1'b1, 2'd0, 32'd0, 32'hFFFF_FFF9, 32'd2, 3'd2, 3'd3);
        run_op(1'b1, 2'd0, 32'd0, 32'hFFFF_8000, 32'd1, 3'd2, 3'd3);
        run_op(1'b1, 2'd0, 32'd0, 32'h0000_8000, 32'd1, 3'd2, 3'd3);
        run_op(1'b1, 2'd0, 32'd0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd2, 3'd3);
        // R8 long form
        run_op(1'b0, 2'd1, 32'd0, 32'hFFFF_FFFF, 32'd1, 3'd4, 3'd5);
        run_op(1'b0, 2'd1, 32'd0, 32'd1000003, 32'd1000, 3'd4, 3'd5);
        run_op(1'b1, 2'd1, 32'd0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd4, 3'd5);
        run_op(1'b1, 2'd1, 32'd0, 32'hFFFF_FF00, 32'd7, 3'd4, 3'd5);
        // R9 wide form
        run_op(1'b0, 2'd2, 32'd1, 32'd0, 32'd1, 3'd6, 3'd7);
        run_op(1'b0, 2'd2, 32'd1, 32'd0, 32'd2, 3'd6, 3'd7);
        run_op(1'b1, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 3'd6, 3'd7);
        run_op(1'b0, 2'd3, 32'd0, 32'd17, 32'd5, 3'd6, 3'd6);
        run_op(1'b1, 2'd2, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 3'd6, 3'd7);
        run_op(1'b0, 2'd2, 32'd9, 32'd9, 32'd0, 3'd6, 3'd7);
        // Random mix with corner values
        for (int i = 0; i < 120; i++) begin
            logic [31:0] h, l, d;
            logic [1:0] f;
            f = 2'($urandom % 3);
            l = pick($urandom % 9);
            d = pick($urandom % 9);
            h = (f == 2'd2) ? (($urandom % 2) ? pick($urandom % 9) : (d >> 2)) : 32'd0;
            run_op(1'($urandom), f, h, l, d, 3'($urandom), 3'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule